// File: doc/BRIEF.md
# Dual-Input-Clock 4-Bit Binary Counter

This block is a 4-bit binary up-counter driven by two count inputs instead of one. One input, `rise_in`, counts on its low-to-high transition, but only while `fall_in` is high. The other input, `fall_in`, counts on its high-to-low transition, but only while `rise_in` is low. Either input can therefore be used as the count clock, and the other then acts as a level enable. An overriding active-high clear input, `mclr`, forces the count to zero at once, whatever the count inputs are doing.

Both count inputs are asynchronous to the block. They are passed through a two-stage synchronizer on the system clock `clk`. Their edges are found by comparing each synchronized sample with the one taken a cycle earlier. The enable level for a given edge is the other input's synchronized level in the cycle before that edge. At most one increment is made per system-clock cycle. The count wraps from 15 to 0, and there is no carry output.

Top module: `dual_edge_counter`

## Requirements
- R1: While `mclr` is high, `count_o` is 0. Raising `mclr` clears the count without waiting for a `clk` edge.
- R2: While `mclr` stays high, transitions on `rise_in` and `fall_in` leave `count_o` at 0.
- R3: A low-to-high transition of `rise_in` while `fall_in` is high increments `count_o` by one.
- R4: A high-to-low transition of `fall_in` while `rise_in` is low increments `count_o` by one.
- R5: The following transitions leave `count_o` unchanged: a high-to-low transition of `rise_in`, a low-to-high transition of `fall_in`, a `rise_in` rise while `fall_in` is low, and a `fall_in` fall while `rise_in` is high.
- R6: The count is a 4-bit binary value, with bit 0 as the least significant bit. An increment from 15 gives 0.
- R7: When a qualifying `rise_in` rise and a qualifying `fall_in` fall arrive together, the count increments exactly once. Example: (`rise_in`,`fall_in`) goes from (0,1) to (1,0).
- R8: The enable level is the other input's level before the edge. An input change made between clock edges shows on `count_o` after the third rising `clk` edge following it, and not after the second.
- R9: An input transition made while `mclr` is high is not counted after `mclr` is released. The first qualifying edge after release gives a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| mclr | input | 1 | Active-high asynchronous master clear |
| rise_in | input | 1 | Count input sensed on its rising edge; enables the other input while low |
| fall_in | input | 1 | Count input sensed on its falling edge; enables the other input while high |
| count_o | output | 4 | Count value, bit 0 least significant |

## Verification
Every qualifying event moves the count by exactly one, and every event that does not qualify moves it by nothing. So a wrong qualification term, a wrong enable level or a stale edge register shows up as a count that is off by one. The error appears at the third clock edge after the offending input change, and it persists in every later reading. A wrong wrap or a wrong carry shows as a value other than 0 after 15. A clear that is not asynchronous shows as a nonzero count inside the same clock cycle in which `mclr` rises. A missing settle guard shows as a count of 1 right after release, when an input had changed during the clear.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int CNT_W = 4;
  localparam int SYNC_STAGES = 2;

  typedef logic [CNT_W-1:0] count_t;

  function automatic count_t count_next(input count_t cur);
    return cur + count_t'(1);
  endfunction

  function automatic logic rise_ok(input logic prev_lvl, input logic cur_lvl,
                                   input logic prev_other);
    return !prev_lvl && cur_lvl && prev_other;
  endfunction

  function automatic logic fall_ok(input logic prev_lvl, input logic cur_lvl,
                                   input logic prev_other);
    return prev_lvl && !cur_lvl && !prev_other;
  endfunction
endpackage

// File: rtl/dec_sync.sv
module dec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d_in;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/dec_edge_qual.sv
module dec_edge_qual
  import dec_pkg::*;
#(
  parameter int SETTLE = SYNC_STAGES
) (
  input  logic clk,
  input  logic mclr,
  input  logic a_s,
  input  logic b_s,
  output logic rise_hit,
  output logic fall_hit,
  output logic cnt_event
);
  localparam int SW = $clog2(SETTLE + 2);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

  logic a_q, b_q;
  logic [SW-1:0] settle_cnt;
  logic settled;

  always_ff @(posedge clk) begin
    a_q <= a_s;
    b_q <= b_s;
  end

  always_ff @(posedge clk or posedge mclr) begin
    if (mclr) settle_cnt <= '0;
    else if (settle_cnt != SETTLE_V) settle_cnt <= settle_cnt + SW'(1);
  end

  assign settled   = (settle_cnt == SETTLE_V) && !mclr;
  assign rise_hit  = rise_ok(a_q, a_s, b_q);
  assign fall_hit  = fall_ok(b_q, b_s, a_q);
  assign cnt_event = settled && (rise_hit || fall_hit);
endmodule

// File: rtl/dec_count.sv
module dec_count
  import dec_pkg::*;
(
  input  logic   clk,
  input  logic   mclr,
  input  logic   step,
  output count_t value
);
  always_ff @(posedge clk or posedge mclr) begin
    if (mclr) value <= '0;
    else if (step) value <= count_next(value);
  end
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter
  import dec_pkg::*;
(
  input  logic             clk,
  input  logic             mclr,
  input  logic             rise_in,
  input  logic             fall_in,
  output logic [CNT_W-1:0] count_o
);
  logic [1:0] synced;
  logic rise_hit, fall_hit, cnt_event;

  dec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .d_in ({fall_in, rise_in}),
    .d_out(synced)
  );

  dec_edge_qual #(.SETTLE(SYNC_STAGES)) u_qual (
    .clk      (clk),
    .mclr     (mclr),
    .a_s      (synced[0]),
    .b_s      (synced[1]),
    .rise_hit (rise_hit),
    .fall_hit (fall_hit),
    .cnt_event(cnt_event)
  );

  dec_count u_cnt (
    .clk  (clk),
    .mclr (mclr),
    .step (cnt_event),
    .value(count_o)
  );
endmodule

// File: rtl/dec_checker.sv
module dec_checker
  import dec_pkg::*;
(
  input logic             clk,
  input logic             mclr,
  input logic             cnt_event,
  input logic [CNT_W-1:0] count_o
);
  // R1: clear holds the count at zero
  always @(negedge clk) begin
    if (mclr) begin
      p_clear_zero_r1: assert (count_o == '0);
    end
  end

  // R3 R4 R7: any change is exactly one step, with wrap (R6)
  p_single_step_r7: assert property (@(posedge clk) disable iff (mclr)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + CNT_W'(1)));

  // R5: no event, no change
  p_hold_no_event_r5: assert property (@(posedge clk) disable iff (mclr)
    !$past(cnt_event) |-> $stable(count_o));

  // R6: an event at 15 gives 0
  p_wrap_r6: assert property (@(posedge clk) disable iff (mclr)
    ($past(cnt_event) && $past(count_o) == '1) |-> (count_o == '0));

  // R9: nothing counted in the first cycle after release
  p_settle_r9: assert property (@(posedge clk) disable iff (mclr)
    $fell(mclr) |-> !cnt_event);
endmodule

bind dual_edge_counter dec_checker u_chk (
  .clk      (clk),
  .mclr     (mclr),
  .cnt_event(cnt_event),
  .count_o  (count_o)
);

// File: tb/dual_edge_counter_test.sv
`timescale 1ns/100ps
module dual_edge_counter_test;
  logic clk = 0, mclr = 1, rise_in = 0, fall_in = 0;
  logic [3:0] count_o;
  int checks = 0, errors = 0;
  int exp = 0;

  always #2.5 clk = ~clk;

  dual_edge_counter uut (.clk(clk), .mclr(mclr), .rise_in(rise_in),
                         .fall_in(fall_in), .count_o(count_o));

  task automatic check(input string req, input int expv);
    checks++;
    if (count_o !== 4'(expv)) begin
      errors++;
      $display("FAIL %s: count_o=%0d expected=%0d", req, count_o, expv);
    end
  endtask

  // model: R3, R4, R7 (single increment), R6 (mod 16)
  task automatic apply(input logic na, input logic nb, input string req);
    int inc;
    @(negedge clk);
    inc = ((!rise_in && na && fall_in) || (fall_in && !nb && !rise_in)) ? 1 : 0;
    rise_in = na; fall_in = nb;
    exp = (exp + inc) % 16;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: count_o=%0d expected=%0d", count_o, exp);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset", 0);
    // R2: edges under clear
    rise_in = 0; fall_in = 1; repeat (4) @(negedge clk);
    rise_in = 1; repeat (4) @(negedge clk);
    fall_in = 0; repeat (4) @(negedge clk);
    check("R2 hold under clear", 0);
    rise_in = 0; fall_in = 1;
    repeat (6) @(negedge clk);
    mclr = 0;
    repeat (6) @(negedge clk);
    check("R9 settled no count", 0);
    exp = 0;
    apply(1, 1, "R3 rise with enable");
    apply(1, 0, "R5 fall while rise high");
    apply(0, 0, "R5 rise falls");
    apply(0, 1, "R5 fall_in rises");
    apply(0, 0, "R4 fall with enable");

    // exhaustive transition sweep: R3 R4 R5 R7
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        apply(f[0], f[1], "R5 sweep setup");
        apply(t[0], t[1], "R3 R4 R5 R7 sweep");
      end
    end

    // R7 explicit: both edges together
    apply(0, 1, "R7 setup");
    begin
      int before_v;
      before_v = exp;
      apply(1, 0, "R7 simultaneous once");
      checks++;
      if (exp != (before_v + 1) % 16) begin
        errors++;
        $display("FAIL R7 model: %0d expected=%0d", exp, (before_v + 1) % 16);
      end
    end

    // R8 latency
    apply(0, 1, "R8 setup");
    @(negedge clk);
    rise_in = 1;
    exp = (exp + 1) % 16;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 not after two edges", (exp + 15) % 16);
    @(posedge clk); @(negedge clk);
    check("R8 after third edge", exp);

    // R6 wrap
    apply(0, 1, "R6 prep");
    while (exp != 15) begin
      apply(1, 1, "R6 climb");
      apply(0, 1, "R6 climb");
    end
    check("R6 at fifteen", 15);
    apply(1, 1, "R6 wrap to zero");
    check("R6 zero", 0);
    apply(0, 1, "R6 after wrap");
    apply(1, 1, "R6 one after wrap");

    // R1 asynchronous clear mid-cycle
    @(posedge clk); #1;
    mclr = 1; #0.5;
    check("R1 async clear", 0);
    exp = 0;
    // R9: edge under clear then release
    @(negedge clk); rise_in = 0; fall_in = 1;
    repeat (4) @(negedge clk);
    rise_in = 1;
    @(negedge clk); mclr = 0;
    repeat (6) @(negedge clk);
    check("R9 no count after release", 0);
    apply(0, 1, "R9 no count");
    apply(1, 1, "R9 first edge gives one");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule